// File: doc/BRIEF.md
# Load/Store Port Protocol Monitor

A passive, synthesizable observer that sits beside one load/store port linking a compute unit to a memory-side handler. Each clock it samples the request strobes, the busy level, the address valid flag with its address, the address acknowledge, the exception pulse and the two completion strobes. It compares them against the handshake rules of the port and reports the first broken rule. It drives nothing on the port and models no memory.

A transaction opens when a load or store request rises together with busy. Busy then stays high until the transaction closes. A load closes in the cycle its data-valid pulse appears. A store closes one cycle after its data-valid pulse. An exception closes either kind at once. When a rule breaks, a sticky error flag and a 3-bit rule code are registered one cycle later. The flag holds until reset, and so does the code of the first rule broken. If several rules break in the same cycle, the lowest code is reported.

Top module: `ldst_port_monitor`

## Requirements
- R1: Load request and store request high in the same cycle is reported with code 1.
- R2: A request rising while busy was already high in the previous cycle, or a request rising in a cycle where busy is low, is reported with code 2.
- R3: Inside a transaction, once address valid has been seen high, address valid low or a changed address in a later cycle while busy is still high is reported with code 3.
- R4: Address acknowledge high in two consecutive cycles, or exception high in two consecutive cycles, is reported with code 4.
- R5: An exception while busy is high, or an exception in a transaction that has already had an address acknowledge (earlier or in the same cycle), is reported with code 5.
- R6: The following are reported with code 6: load-valid while busy is high, load-valid outside a load transaction (including a second consecutive load-valid), or busy falling during a load with neither load-valid nor exception in that cycle.
- R7: The following are reported with code 7: store-valid outside a store transaction, store-valid with no address acknowledge in an earlier cycle of the transaction, busy still high in the cycle after store-valid, or busy falling during a store in any cycle other than the one after store-valid (an exception excepted).
- R8: The error flag and code appear one clock after the offending cycle. They then never change until reset, so a later violation keeps the first code. When rules break together, the lowest code wins.
- R9: Reset (synchronous, active high) clears flag and code to 0. Legal load, store and exception transactions leave the flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | Load request strobe |
| st_req | input | 1 | Store request strobe |
| busy | input | 1 | Port busy level from the handler |
| addr_vld | input | 1 | Address valid from the compute unit |
| addr | input | AW | Address value |
| addr_ack | input | 1 | Address acknowledge pulse |
| exc | input | 1 | Exception pulse |
| ld_vld | input | 1 | Load data valid pulse |
| st_vld | input | 1 | Store data valid pulse |
| err | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first rule broken (0 when clean) |

## Verification
The bench goes after the closing cycle of each transaction kind. If a monitor confused load and store timing, it would flag a legal store whose busy falls one cycle after store-valid, or it would miss a load whose busy stays high. Exceptions are hit at the edge: the first one-cycle exception must pass, while a second consecutive one, one with busy still high, or one after an acknowledge must be caught. A tracker that failed to reset its acknowledge memory would then flag clean traffic. Random legal traffic of mixed kinds and delays catches false alarms. Stacked violations check that the code is sticky and that the lowest code wins when several rules break at once.

// File: rtl/ldst_mon_pkg.sv
package ldst_mon_pkg;
  localparam int NRULE = 7;
  localparam int CW    = $clog2(NRULE + 1);

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_LD   = 2'd1,
    TX_ST   = 2'd2
  } txn_t;

  typedef enum logic [CW-1:0] {
    RC_NONE   = 3'd0,
    RC_BOTH   = 3'd1,
    RC_REQBSY = 3'd2,
    RC_ADDR   = 3'd3,
    RC_PULSE  = 3'd4,
    RC_EXC    = 3'd5,
    RC_LOAD   = 3'd6,
    RC_STORE  = 3'd7
  } rule_t;
endpackage

// File: rtl/ldst_mon_hist.sv
module ldst_mon_hist #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          busy,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr,
  input  logic          addr_ack,
  input  logic          exc,
  input  logic          st_vld,
  output logic          req_q,
  output logic          busy_q,
  output logic          addr_vld_q,
  output logic [AW-1:0] addr_q,
  output logic          ack_q,
  output logic          exc_q,
  output logic          st_vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= 1'b0;
      busy_q     <= 1'b0;
      addr_vld_q <= 1'b0;
      addr_q     <= '0;
      ack_q      <= 1'b0;
      exc_q      <= 1'b0;
      st_vld_q   <= 1'b0;
    end else begin
      req_q      <= req;
      busy_q     <= busy;
      addr_vld_q <= addr_vld;
      addr_q     <= addr;
      ack_q      <= addr_ack;
      exc_q      <= exc;
      st_vld_q   <= st_vld;
    end
  end
endmodule

// File: rtl/ldst_mon_txn.sv
module ldst_mon_txn
  import ldst_mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ld_req,
  input  logic req_new,
  input  logic busy,
  input  logic busy_q,
  input  logic addr_ack,
  output txn_t txn_q,
  output txn_t txn_cur,
  output logic acked_q,
  output logic fall
);
  logic start;

  always_comb begin
    fall    = busy_q & ~busy;
    start   = req_new & busy & ~busy_q & (txn_q == TX_IDLE);
    txn_cur = txn_q;
    if (start) txn_cur = ld_req ? TX_LD : TX_ST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txn_q   <= TX_IDLE;
      acked_q <= 1'b0;
    end else begin
      txn_q   <= fall ? TX_IDLE : txn_cur;
      acked_q <= (fall || txn_cur == TX_IDLE) ? 1'b0 : (acked_q | addr_ack);
    end
  end

  AST_FALL_CLOSES: assert property (@(posedge clk) disable iff (rst)
    fall |=> (txn_q == TX_IDLE)); // R6
  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (txn_q == TX_IDLE) |-> !acked_q); // R5
endmodule

// File: rtl/ldst_mon_rules.sv
module ldst_mon_rules
  import ldst_mon_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          ld_req,
  input  logic          st_req,
  input  logic          req_new,
  input  logic          busy,
  input  logic          busy_q,
  input  logic          addr_vld,
  input  logic          addr_vld_q,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] addr_q,
  input  logic          addr_ack,
  input  logic          ack_q,
  input  logic          exc,
  input  logic          exc_q,
  input  logic          ld_vld,
  input  logic          st_vld,
  input  logic          st_vld_q,
  input  txn_t          txn_q,
  input  txn_t          txn_cur,
  input  logic          acked_q,
  input  logic          fall,
  output logic [NRULE:1] viol
);
  logic ld_bad_strobe, ld_bad_end, st_bad_strobe, st_bad_hold, st_bad_end;

  always_comb begin
    ld_bad_strobe = ld_vld & (busy | (txn_cur != TX_LD));
    ld_bad_end    = fall & (txn_q == TX_LD) & ~ld_vld & ~exc;
    st_bad_strobe = st_vld & ((txn_cur != TX_ST) | ~acked_q);
    st_bad_hold   = st_vld_q & busy;
    st_bad_end    = fall & (txn_q == TX_ST) & ~st_vld_q & ~exc;

    viol[RC_BOTH]   = ld_req & st_req;
    viol[RC_REQBSY] = req_new & (busy_q | ~busy);
    viol[RC_ADDR]   = busy & busy_q & (txn_q != TX_IDLE) & addr_vld_q &
                      (~addr_vld | (addr != addr_q));
    viol[RC_PULSE]  = (addr_ack & ack_q) | (exc & exc_q);
    viol[RC_EXC]    = exc & (busy | acked_q | addr_ack);
    viol[RC_LOAD]   = ld_bad_strobe | ld_bad_end;
    viol[RC_STORE]  = st_bad_strobe | st_bad_hold | st_bad_end;
  end
endmodule

// File: rtl/ldst_mon_latch.sv
module ldst_mon_latch
  import ldst_mon_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [NRULE:1] viol,
  output logic           err_q,
  output logic [CW-1:0]  code_q
);
  logic [CW-1:0] first;

  always_comb begin
    first = '0;
    for (int i = NRULE; i >= 1; i--) begin
      if (viol[i]) first = i[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= 1'b0;
      code_q <= '0;
    end else if (!err_q && (|viol)) begin
      err_q  <= 1'b1;
      code_q <= first;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> (err_q && $stable(code_q))); // R8
  AST_FIRST_CAUGHT: assert property (@(posedge clk) disable iff (rst)
    (!err_q && (|viol)) |=> err_q); // R8
  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (code_q != '0)); // R8
endmodule

// File: rtl/ldst_port_monitor.sv
module ldst_port_monitor
  import ldst_mon_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_req,
  input  logic          st_req,
  input  logic          busy,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr,
  input  logic          addr_ack,
  input  logic          exc,
  input  logic          ld_vld,
  input  logic          st_vld,
  output logic          err,
  output logic [2:0]    err_code
);
  logic          req, req_new;
  logic          req_q, busy_q, addr_vld_q, ack_q, exc_q, st_vld_q;
  logic [AW-1:0] addr_q;
  txn_t          txn_q, txn_cur;
  logic          acked_q, fall;
  logic [NRULE:1] viol;
  logic [CW-1:0] code_q;

  assign req     = ld_req | st_req;
  assign req_new = req & ~req_q;

  ldst_mon_hist #(.AW(AW)) u_hist (
    .clk(clk), .rst(rst), .req(req), .busy(busy), .addr_vld(addr_vld),
    .addr(addr), .addr_ack(addr_ack), .exc(exc), .st_vld(st_vld),
    .req_q(req_q), .busy_q(busy_q), .addr_vld_q(addr_vld_q),
    .addr_q(addr_q), .ack_q(ack_q), .exc_q(exc_q), .st_vld_q(st_vld_q)
  );

  ldst_mon_txn u_txn (
    .clk(clk), .rst(rst), .ld_req(ld_req), .req_new(req_new), .busy(busy),
    .busy_q(busy_q), .addr_ack(addr_ack), .txn_q(txn_q), .txn_cur(txn_cur),
    .acked_q(acked_q), .fall(fall)
  );

  ldst_mon_rules #(.AW(AW)) u_rules (
    .ld_req(ld_req), .st_req(st_req), .req_new(req_new), .busy(busy),
    .busy_q(busy_q), .addr_vld(addr_vld), .addr_vld_q(addr_vld_q),
    .addr(addr), .addr_q(addr_q), .addr_ack(addr_ack), .ack_q(ack_q),
    .exc(exc), .exc_q(exc_q), .ld_vld(ld_vld), .st_vld(st_vld),
    .st_vld_q(st_vld_q), .txn_q(txn_q), .txn_cur(txn_cur),
    .acked_q(acked_q), .fall(fall), .viol(viol)
  );

  ldst_mon_latch u_latch (
    .clk(clk), .rst(rst), .viol(viol), .err_q(err), .code_q(code_q)
  );

  assign err_code = code_q;

  AST_BOTH_REQ: assert property (@(posedge clk) disable iff (rst)
    (ld_req && st_req && !err) |=> (err && err_code == 3'd1)); // R1
  AST_EXC_BUSY: assert property (@(posedge clk) disable iff (rst)
    (exc && busy) |=> err); // R5
  AST_LD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (ld_vld && busy) |=> err); // R6
endmodule

// File: tb/tb_ldst_port_monitor.sv
module tb_ldst_port_monitor;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst, ld_req, st_req, busy, addr_vld, addr_ack, exc, ld_vld, st_vld;
  logic [AW-1:0] addr;
  logic err;
  logic [2:0] err_code;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ldst_port_monitor #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .ld_req(ld_req), .st_req(st_req), .busy(busy),
    .addr_vld(addr_vld), .addr(addr), .addr_ack(addr_ack), .exc(exc),
    .ld_vld(ld_vld), .st_vld(st_vld), .err(err), .err_code(err_code)
  );

  function automatic logic [2:0] first_code(input logic [7:1] v);
    logic [2:0] c = 3'd0;
    for (int i = 7; i >= 1; i--) if (v[i]) c = i[2:0];
    return c;
  endfunction

  task automatic cyc(input logic l, s, b, av, input logic [AW-1:0] a,
                     input logic ak, ex, lv, sv);
    ld_req = l; st_req = s; busy = b; addr_vld = av; addr = a;
    addr_ack = ak; exc = ex; ld_vld = lv; st_vld = sv;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, '0, 0, 0, 0, 0);
  endtask

  task automatic chk(input string r, input logic e_err, input logic [2:0] e_code);
    nchk++;
    if (err !== e_err || err_code !== e_code) begin
      nbad++;
      $display("FAIL %s: err=%0b code=%0d expected err=%0b code=%0d",
               r, err, err_code, e_err, e_code);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) idle();
    rst = 1'b0;
  endtask

  // kind 0 load, 1 store, 2 exception (load-started)
  task automatic legal(input int kind, input logic [AW-1:0] a, input int dly);
    cyc(kind != 1, kind == 1, 1, 1, a, 0, 0, 0, 0);
    for (int i = 0; i < dly; i++) cyc(0, 0, 1, 1, a, 0, 0, 0, 0);
    if (kind == 2) begin
      cyc(0, 0, 0, 1, a, 0, 1, 0, 0);
    end else begin
      cyc(0, 0, 1, 1, a, 1, 0, 0, 0);
      for (int i = 0; i < dly; i++) cyc(0, 0, 1, 1, a, 0, 0, 0, 0);
      if (kind == 0) cyc(0, 0, 0, 1, a, 0, 0, 1, 0);
      else begin
        cyc(0, 0, 1, 1, a, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, '0, 0, 0, 0, 0);
      end
    end
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: err=%0b code=%0d expected completion", err, err_code);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    ld_req = 0; st_req = 0; busy = 0; addr_vld = 0; addr = '0;
    addr_ack = 0; exc = 0; ld_vld = 0; st_vld = 0;
    @(negedge clk);
    do_reset();
    chk("R9 reset state", 0, 0);

    legal(0, 16'h1234, 0); chk("R9 legal load", 0, 0);
    legal(1, 16'h0042, 2); chk("R9 legal store", 0, 0);
    legal(2, 16'h00f0, 1); chk("R9 legal exception", 0, 0);

    for (int n = 0; n < 60; n++)
      legal(int'($urandom_range(2, 0)), AW'($urandom), int'($urandom_range(3, 0)));
    chk("R9 random legal traffic", 0, 0);

    // R1 both requests; with busy low R2 also breaks, lowest wins (R8)
    do_reset(); cyc(1, 1, 1, 1, 16'h1, 0, 0, 0, 0); chk("R1 both requests", 1, 1);
    do_reset(); cyc(1, 1, 0, 1, 16'h1, 0, 0, 0, 0);
    chk("R8 lowest code wins", 1, first_code(7'b0000011));

    // R2
    do_reset(); cyc(1, 0, 1, 1, 16'h5, 0, 0, 0, 0); cyc(0, 0, 1, 1, 16'h5, 0, 0, 0, 0);
    chk("R2 pre-check clean", 0, 0);
    cyc(1, 0, 1, 1, 16'h5, 0, 0, 0, 0); chk("R2 request while busy", 1, 2);
    do_reset(); cyc(0, 1, 0, 1, 16'h5, 0, 0, 0, 0); chk("R2 busy not raised", 1, 2);

    // R3
    do_reset(); cyc(1, 0, 1, 1, 16'h7, 0, 0, 0, 0); cyc(0, 0, 1, 1, 16'h8, 0, 0, 0, 0);
    chk("R3 address changed", 1, 3);
    do_reset(); cyc(0, 1, 1, 1, 16'h7, 0, 0, 0, 0); cyc(0, 0, 1, 0, 16'h7, 0, 0, 0, 0);
    chk("R3 address valid dropped", 1, 3);

    // R4
    do_reset(); cyc(1, 0, 1, 1, 16'h9, 0, 0, 0, 0); cyc(0, 0, 1, 1, 16'h9, 1, 0, 0, 0);
    cyc(0, 0, 1, 1, 16'h9, 1, 0, 0, 0); chk("R4 acknowledge two cycles", 1, 4);
    do_reset(); cyc(1, 0, 1, 1, 16'h9, 0, 0, 0, 0); cyc(0, 0, 0, 1, 16'h9, 0, 1, 0, 0);
    chk("R4 first exception legal", 0, 0);
    cyc(0, 0, 0, 0, '0, 0, 1, 0, 0); chk("R4 exception two cycles", 1, 4);

    // R5
    do_reset(); cyc(1, 0, 1, 1, 16'ha, 0, 0, 0, 0); cyc(0, 0, 1, 1, 16'ha, 0, 1, 0, 0);
    chk("R5 exception with busy high", 1, 5);
    do_reset(); cyc(0, 1, 1, 1, 16'ha, 0, 0, 0, 0); cyc(0, 0, 1, 1, 16'ha, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 16'ha, 0, 1, 0, 0); chk("R5 exception after acknowledge", 1, 5);

    // R6
    do_reset(); cyc(1, 0, 1, 1, 16'hb, 0, 0, 0, 0); cyc(0, 0, 1, 1, 16'hb, 1, 0, 0, 0);
    cyc(0, 0, 1, 1, 16'hb, 0, 0, 1, 0); chk("R6 load valid with busy high", 1, 6);
    do_reset(); cyc(1, 0, 1, 1, 16'hb, 0, 0, 0, 0); cyc(0, 0, 1, 1, 16'hb, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 16'hb, 0, 0, 0, 0); chk("R6 busy dropped without data", 1, 6);
    do_reset(); cyc(1, 0, 1, 1, 16'hb, 1, 0, 0, 0); cyc(0, 0, 0, 1, 16'hb, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, '0, 0, 0, 1, 0); chk("R6 second load valid", 1, 6);

    // R7
    do_reset(); cyc(0, 1, 1, 1, 16'hc, 0, 0, 0, 0); cyc(0, 0, 1, 1, 16'hc, 0, 0, 0, 1);
    chk("R7 store valid before acknowledge", 1, 7);
    do_reset(); cyc(0, 1, 1, 1, 16'hc, 1, 0, 0, 0); cyc(0, 0, 1, 1, 16'hc, 0, 0, 0, 1);
    chk("R7 store valid legal", 0, 0);
    cyc(0, 0, 1, 1, 16'hc, 0, 0, 0, 0); chk("R7 busy held after store", 1, 7);
    do_reset(); cyc(0, 1, 1, 1, 16'hc, 1, 0, 0, 0); cyc(0, 0, 0, 1, 16'hc, 0, 0, 0, 1);
    chk("R7 busy dropped with store valid", 1, 7);

    // R8 sticky first code
    do_reset(); cyc(1, 0, 1, 1, 16'hd, 0, 0, 0, 0); cyc(0, 0, 1, 1, 16'he, 0, 0, 0, 0);
    cyc(1, 1, 1, 1, 16'he, 0, 0, 0, 0); idle(); chk("R8 first code sticky", 1, 3);
    do_reset(); chk("R9 reset clears error", 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule